// File: doc/BRIEF.md
# Bank-Switchable Two-Port Word Memory

This block is a word memory with two independent ports, left and right, split into four equal banks. Neither port arbitrates with the other. Instead, an external select line for each bank hands that whole bank to one port. Both ports can therefore run every cycle at full rate, as long as they work in different banks.

Each port has its own controls:
- two chip enables,
- a read/write strobe,
- an output enable,
- upper and lower byte-lane enables,
- a two-bit bank number and an in-bank word address,
- a write bus, a read bus and an access-error flag.

The block is synchronous. Inputs are sampled on the rising clock edge, and read data is registered. The in-bank address width is the parameter `WORD_AW`. The full organisation of 16K words per bank (64K words of 16 bits in total) uses `WORD_AW = 14`. The default is a smaller 256-word bank.

Each port runs a small state machine whose state register records what that port did at the last edge. The states are:
- `P_IDLE`: no access.
- `P_READ`: an owned read.
- `P_WRITE`: an owned write.
- `P_DENY`: an access aimed at a bank owned by the other port.

At every edge the next state is chosen as follows:
- Chip enables not both high: go to `P_IDLE`.
- Enabled, but the bank select names the other side: go to `P_DENY`.
- Enabled and owned, with the write strobe high: go to `P_WRITE`.
- Enabled and owned, with the write strobe low: go to `P_READ`.

Any state can move to any other at each edge. The output process drives the read bus and the error flag from the current state.

Top module: `bsdp_top`

## Requirements
- R1: The 2-bit bank number selects one of four banks and the word address selects a word in it. Data written at a (bank, word) pair reads back from that pair, and writes to one pair leave every other pair unchanged.
- R2: `bank_sel[i]` = 0 gives bank i to the left port and 1 gives it to the right port. The value is taken at each rising edge, and bank contents survive a change of owner.
- R3: `*_ub` enables bits 15:8 and `*_lb` enables bits 7:0. A write changes only the enabled lanes, and a read returns zero in any lane whose enable was low at the read edge.
- R4: An enabled access to a bank the port does not own has the following effects:
    - A write is ignored.
    - The read bus shows zero in the following cycle.
    - The port's error flag is high for exactly that following cycle.
- R5: An access takes place only when both chip enables of the port are high. Otherwise nothing is written, and in the following cycle the read bus is zero and the error flag is low.
- R6: Read data for an address sampled at an edge appears in the cycle after that edge. It appears only if the output enable was high at that edge; otherwise the read bus is zero.
- R7: Both ports can read or write in the same cycle on different banks, each with its own correct result.
- R8: While reset is asserted and after its release, both read buses are zero and both error flags are low until the first access.
- R9: A strobe value of 1 writes and 0 reads. In the cycle after an owned write, the read bus is zero and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| bank_sel | input | 4 | Per-bank owner: 0 = left port, 1 = right port |
| l_en0 | input | 1 | Left chip enable 0 (active high) |
| l_en1 | input | 1 | Left chip enable 1 (active high) |
| l_wr | input | 1 | Left strobe: 1 write, 0 read |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper-byte lane enable |
| l_lb | input | 1 | Left lower-byte lane enable |
| l_bank | input | 2 | Left bank number |
| l_addr | input | WORD_AW | Left in-bank word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_err | output | 1 | Left access-error flag |
| r_en0 | input | 1 | Right chip enable 0 (active high) |
| r_en1 | input | 1 | Right chip enable 1 (active high) |
| r_wr | input | 1 | Right strobe: 1 write, 0 read |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper-byte lane enable |
| r_lb | input | 1 | Right lower-byte lane enable |
| r_bank | input | 2 | Right bank number |
| r_addr | input | WORD_AW | Right in-bank word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_err | output | 1 | Right access-error flag |

## Verification
The memory is first filled through the left port with a pattern that encodes both the bank and the word. Readback then shows whether bank and word decoding (R1) are correct.

Several directed patterns follow, each separating one mechanism from the others:
- **Ownership swap:** the right port reads what the left port wrote. This tells a correct handover apart from an ownership inversion.
- **Foreign access:** a foreign write is followed by a read by the owner. This separates a blocked write from a leaked write.
- **Single-lane writes and reads:** these show lane gating in each direction.
- **One chip enable low, or output enable low:** these show which qualifier gates the access.

A long random phase then drives both ports every cycle with random ownership, lanes and controls. This exposes cross-port interference that the directed cases miss.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;

    // Per-port record of what happened at the last clock edge.
    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_READ  = 2'd1,
        P_WRITE = 2'd2,
        P_DENY  = 2'd3
    } port_state_e;

endpackage

// File: rtl/bsdp_port.sv
module bsdp_port
    import bsdp_pkg::*;
#(
    parameter int unsigned NBANK   = 4,
    parameter int unsigned WORD_AW = 8,
    parameter int unsigned LANE_W  = 8,
    parameter int unsigned LANES   = 2,
    parameter bit          SIDE    = 1'b0,
    localparam int unsigned BANK_AW = $clog2(NBANK),
    localparam int unsigned DATA_W  = LANE_W * LANES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NBANK-1:0]               bank_sel,
    input  logic                           en0,
    input  logic                           en1,
    input  logic                           wr,
    input  logic                           oe,
    input  logic [LANES-1:0]               lanes,
    input  logic [BANK_AW-1:0]             bank,
    input  logic [WORD_AW-1:0]             addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NBANK-1:0][DATA_W-1:0]   bank_rd,
    output logic                           req_we,
    output logic                           req_re,
    output logic [BANK_AW-1:0]             req_bank,
    output logic [WORD_AW-1:0]             req_addr,
    output logic [DATA_W-1:0]              req_wdata,
    output logic [LANES-1:0]               req_lanes,
    output logic [DATA_W-1:0]              rdata,
    output logic                           err
);

    port_state_e        st_q, st_d;
    logic [BANK_AW-1:0] bank_q;
    logic [LANES-1:0]   lanes_q;
    logic               oe_q;
    logic               active;
    logic               owned;
    logic [DATA_W-1:0]  mask_q;
    logic [DATA_W-1:0]  picked;

    assign active = en0 & en1;
    assign owned  = (bank_sel[bank] == SIDE);

    // Next-state selection.
    always_comb begin
        unique case ({active, owned, wr})
            3'b000, 3'b001, 3'b010, 3'b011: st_d = P_IDLE;
            3'b100, 3'b101:                 st_d = P_DENY;
            3'b111:                         st_d = P_WRITE;
            3'b110:                         st_d = P_READ;
            default:                        st_d = P_IDLE;
        endcase
    end

    // State register and captured read qualifiers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= P_IDLE;
            bank_q  <= '0;
            lanes_q <= '0;
            oe_q    <= 1'b0;
        end else begin
            st_q    <= st_d;
            bank_q  <= bank;
            lanes_q <= lanes;
            oe_q    <= oe;
        end
    end

    // Requests towards the banks, qualified by enables and ownership.
    always_comb begin
        req_we    = active & owned & wr;
        req_re    = active & owned & ~wr;
        req_bank  = bank;
        req_addr  = addr;
        req_wdata = wdata;
        req_lanes = lanes;
    end

    // Lane mask expanded from the captured byte enables.
    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            mask_q[i*LANE_W +: LANE_W] = {LANE_W{lanes_q[i]}};
        end
    end

    assign picked = bank_rd[bank_q];

    // Output process.
    always_comb begin
        rdata = '0;
        err   = 1'b0;
        unique case (st_q)
            P_IDLE:  begin rdata = '0; err = 1'b0; end
            P_READ:  begin rdata = oe_q ? (picked & mask_q) : '0; err = 1'b0; end
            P_WRITE: begin rdata = '0; err = 1'b0; end
            P_DENY:  begin rdata = '0; err = 1'b1; end
        endcase
    end

    // R4: an enabled foreign access raises the flag one cycle later.
    a_r4_foreign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !owned) |=> (err && rdata == '0));

    // R5: disabled port stays quiet.
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (!err && rdata == '0));

    // R6: read with output enable low yields zero.
    a_r6_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (active && owned && !wr && !oe) |=> (rdata == '0));

    // R9: an owned write shows nothing on the read side.
    a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (active && owned && wr) |=> (rdata == '0 && !err));

endmodule

// File: rtl/bsdp_bank.sv
module bsdp_bank #(
    parameter int unsigned WORD_AW = 8,
    parameter int unsigned LANE_W  = 8,
    parameter int unsigned LANES   = 2,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned DEPTH  = 1 << WORD_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               l_we,
    input  logic               l_re,
    input  logic [WORD_AW-1:0] l_addr,
    input  logic [DATA_W-1:0]  l_wdata,
    input  logic [LANES-1:0]   l_lanes,
    input  logic               r_we,
    input  logic               r_re,
    input  logic [WORD_AW-1:0] r_addr,
    input  logic [DATA_W-1:0]  r_wdata,
    input  logic [LANES-1:0]   r_lanes,
    output logic [DATA_W-1:0]  rd_data
);

    logic [DATA_W-1:0]  mem [DEPTH];
    logic               we, re;
    logic [WORD_AW-1:0] addr;
    logic [DATA_W-1:0]  wdata;
    logic [LANES-1:0]   lanes;

    // The owner side alone reaches the array.
    always_comb begin
        if (sel) begin
            we = r_we; re = r_re; addr = r_addr; wdata = r_wdata; lanes = r_lanes;
        end else begin
            we = l_we; re = l_re; addr = l_addr; wdata = l_wdata; lanes = l_lanes;
        end
    end

    // Byte-lane write.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < int'(LANES); i++) begin
                if (lanes[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    // Registered read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rd_data <= '0;
        else if (re) rd_data <= mem[addr];
    end

    // R2: never two writers on one bank.
    a_r2_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_we && r_we));

    // R2: a request reaches the bank only from the side its select names.
    a_r2_left_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (l_we || l_re) |-> !sel);
    a_r2_right_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (r_we || r_re) |-> sel);

endmodule

// File: rtl/bsdp_top.sv
module bsdp_top #(
    parameter int unsigned WORD_AW = 8,
    localparam int unsigned NBANK   = 4,
    localparam int unsigned LANE_W  = 8,
    localparam int unsigned LANES   = 2,
    localparam int unsigned BANK_AW = $clog2(NBANK),
    localparam int unsigned DATA_W  = LANE_W * LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NBANK-1:0]   bank_sel,
    input  logic               l_en0,
    input  logic               l_en1,
    input  logic               l_wr,
    input  logic               l_oe,
    input  logic               l_ub,
    input  logic               l_lb,
    input  logic [BANK_AW-1:0] l_bank,
    input  logic [WORD_AW-1:0] l_addr,
    input  logic [DATA_W-1:0]  l_wdata,
    output logic [DATA_W-1:0]  l_rdata,
    output logic               l_err,
    input  logic               r_en0,
    input  logic               r_en1,
    input  logic               r_wr,
    input  logic               r_oe,
    input  logic               r_ub,
    input  logic               r_lb,
    input  logic [BANK_AW-1:0] r_bank,
    input  logic [WORD_AW-1:0] r_addr,
    input  logic [DATA_W-1:0]  r_wdata,
    output logic [DATA_W-1:0]  r_rdata,
    output logic               r_err
);

    logic [NBANK-1:0][DATA_W-1:0] bank_rd;

    logic               lq_we, lq_re, rq_we, rq_re;
    logic [BANK_AW-1:0] lq_bank, rq_bank;
    logic [WORD_AW-1:0] lq_addr, rq_addr;
    logic [DATA_W-1:0]  lq_wdata, rq_wdata;
    logic [LANES-1:0]   lq_lanes, rq_lanes;

    bsdp_port #(.NBANK(NBANK), .WORD_AW(WORD_AW), .LANE_W(LANE_W), .LANES(LANES), .SIDE(1'b0)) u_left (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .en0(l_en0), .en1(l_en1), .wr(l_wr), .oe(l_oe), .lanes({l_ub, l_lb}),
        .bank(l_bank), .addr(l_addr), .wdata(l_wdata), .bank_rd(bank_rd),
        .req_we(lq_we), .req_re(lq_re), .req_bank(lq_bank), .req_addr(lq_addr),
        .req_wdata(lq_wdata), .req_lanes(lq_lanes), .rdata(l_rdata), .err(l_err)
    );

    bsdp_port #(.NBANK(NBANK), .WORD_AW(WORD_AW), .LANE_W(LANE_W), .LANES(LANES), .SIDE(1'b1)) u_right (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .en0(r_en0), .en1(r_en1), .wr(r_wr), .oe(r_oe), .lanes({r_ub, r_lb}),
        .bank(r_bank), .addr(r_addr), .wdata(r_wdata), .bank_rd(bank_rd),
        .req_we(rq_we), .req_re(rq_re), .req_bank(rq_bank), .req_addr(rq_addr),
        .req_wdata(rq_wdata), .req_lanes(rq_lanes), .rdata(r_rdata), .err(r_err)
    );

    for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
        logic hit_l, hit_r;
        assign hit_l = (lq_bank == BANK_AW'(b));
        assign hit_r = (rq_bank == BANK_AW'(b));

        bsdp_bank #(.WORD_AW(WORD_AW), .LANE_W(LANE_W), .LANES(LANES)) u_bank (
            .clk(clk), .rst_n(rst_n), .sel(bank_sel[b]),
            .l_we(lq_we & hit_l), .l_re(lq_re & hit_l), .l_addr(lq_addr),
            .l_wdata(lq_wdata), .l_lanes(lq_lanes),
            .r_we(rq_we & hit_r), .r_re(rq_re & hit_r), .r_addr(rq_addr),
            .r_wdata(rq_wdata), .r_lanes(rq_lanes),
            .rd_data(bank_rd[b])
        );
    end

    // R8: outputs quiet during reset.
    always_comb begin
        if (!rst_n) begin
            a_r8_reset_quiet: assert (l_rdata == '0 && r_rdata == '0 && !l_err && !r_err);
        end
    end

endmodule

// File: tb/tb_bsdp_top.sv
module tb_bsdp_top;

    localparam int CLK_PERIOD = 10;
    localparam int WAW   = 8;
    localparam int DEPTH = 1 << WAW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] bank_sel = '0;
    logic l_en0 = 0, l_en1 = 0, l_wr = 0, l_oe = 0, l_ub = 0, l_lb = 0;
    logic r_en0 = 0, r_en1 = 0, r_wr = 0, r_oe = 0, r_ub = 0, r_lb = 0;
    logic [1:0] l_bank = '0, r_bank = '0;
    logic [WAW-1:0] l_addr = '0, r_addr = '0;
    logic [15:0] l_wdata = '0, r_wdata = '0;
    logic [15:0] l_rdata, r_rdata;
    logic l_err, r_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_tag = "R1";

    int unsigned model [4*DEPTH];
    logic [15:0] exp_l_rd, exp_r_rd;
    logic        exp_l_err, exp_r_err;
    string       tag_l, tag_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsdp_top #(.WORD_AW(WAW)) dut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .l_en0(l_en0), .l_en1(l_en1), .l_wr(l_wr), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
        .l_bank(l_bank), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_err(l_err),
        .r_en0(r_en0), .r_en1(r_en1), .r_wr(r_wr), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
        .r_bank(r_bank), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_err(r_err)
    );

    function automatic logic [15:0] pat(int b, int w);
        return 16'((b * 16'h1357) ^ (w * 16'h0101) ^ 16'hA55A);
    endfunction

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic set_l(bit e0, bit e1, bit w, bit oe, bit ub, bit lb, int b, int a, logic [15:0] d);
        l_en0 = e0; l_en1 = e1; l_wr = w; l_oe = oe; l_ub = ub; l_lb = lb;
        l_bank = 2'(b); l_addr = WAW'(a); l_wdata = d;
    endtask

    task automatic set_r(bit e0, bit e1, bit w, bit oe, bit ub, bit lb, int b, int a, logic [15:0] d);
        r_en0 = e0; r_en1 = e1; r_wr = w; r_oe = oe; r_ub = ub; r_lb = lb;
        r_bank = 2'(b); r_addr = WAW'(a); r_wdata = d;
    endtask

    // Behavioural reference for one port at one edge: read part.
    task automatic predict(bit side, bit e0, bit e1, bit w, bit oe, bit ub, bit lb,
                           int b, int a, output logic [15:0] rd, output logic er, output string tag);
        bit act = e0 & e1;
        bit own = (bank_sel[b] == side);
        logic [15:0] m = {{8{ub}}, {8{lb}}};
        rd = '0; er = 1'b0; tag = cur_tag;
        if (!act)          tag = "R5";
        else if (!own) begin er = 1'b1; tag = "R4"; end
        else if (w)        tag = "R9";
        else if (!oe)      tag = "R6";
        else begin
            rd = 16'(model[b*DEPTH + a]) & m;
            if (!(ub && lb)) tag = "R3";
        end
    endtask

    task automatic commit(bit side, bit e0, bit e1, bit w, bit ub, bit lb, int b, int a, logic [15:0] d);
        logic [15:0] old;
        if (e0 && e1 && w && bank_sel[b] == side) begin
            old = 16'(model[b*DEPTH + a]);
            if (ub) old[15:8] = d[15:8];
            if (lb) old[7:0]  = d[7:0];
            model[b*DEPTH + a] = old;
        end
    endtask

    // One cycle: predict from current inputs, pass the edge, compare at the next falling edge.
    task automatic tick();
        predict(1'b0, l_en0, l_en1, l_wr, l_oe, l_ub, l_lb, int'(l_bank), int'(l_addr), exp_l_rd, exp_l_err, tag_l);
        predict(1'b1, r_en0, r_en1, r_wr, r_oe, r_ub, r_lb, int'(r_bank), int'(r_addr), exp_r_rd, exp_r_err, tag_r);
        commit(1'b0, l_en0, l_en1, l_wr, l_ub, l_lb, int'(l_bank), int'(l_addr), l_wdata);
        commit(1'b1, r_en0, r_en1, r_wr, r_ub, r_lb, int'(r_bank), int'(r_addr), r_wdata);
        @(posedge clk);
        @(negedge clk);
        check(tag_l, "left rdata", l_rdata, exp_l_rd);
        check(exp_l_err ? "R4" : tag_l, "left err", 16'(l_err), 16'(exp_l_err));
        check(tag_r, "right rdata", r_rdata, exp_r_rd);
        check(exp_r_err ? "R4" : tag_r, "right err", 16'(r_err), 16'(exp_r_err));
    endtask

    task automatic idle_both();
        set_l(0, 0, 0, 0, 0, 0, 0, 0, '0);
        set_r(0, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8", "left rdata in reset", l_rdata, '0);
        check("R8", "right err in reset", 16'(r_err), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "left rdata after reset", l_rdata, '0);
        check("R8", "right rdata after reset", r_rdata, '0);

        // R1: fill every bank from the left port, then read back
        cur_tag = "R1";
        bank_sel = 4'b0000;
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < DEPTH; w++) begin
                set_l(1, 1, 1, 1, 1, 1, b, w, pat(b, w));
                tick();
            end
        end
        for (int b = 0; b < 4; b++) begin
            set_l(1, 1, 0, 1, 1, 1, b, 7 * b + 3, '0);
            tick();
        end

        // R2: hand banks 0 and 2 to the right; right reads left's data
        cur_tag = "R2";
        bank_sel = 4'b0101;
        set_l(1, 1, 0, 1, 1, 1, 1, 9, '0);
        set_r(1, 1, 0, 1, 1, 1, 0, 9, '0);
        tick();
        set_r(1, 1, 0, 1, 1, 1, 2, DEPTH - 1, '0);
        tick();

        // R4: left touches bank 0 now owned by right
        set_r(0, 0, 0, 0, 0, 0, 0, 0, '0);
        set_l(1, 1, 1, 1, 1, 1, 0, 4, 16'hDEAD);
        tick();
        set_l(1, 1, 0, 1, 1, 1, 0, 4, '0);
        tick();
        idle_both();
        set_r(1, 1, 0, 1, 1, 1, 0, 4, '0);   // R4: foreign write left no trace
        tick();

        // R3: right writes upper lane only, then reads with each lane
        set_r(1, 1, 1, 1, 1, 0, 2, 5, 16'hBEEF);
        tick();
        set_r(1, 1, 0, 1, 1, 1, 2, 5, '0);
        tick();
        set_r(1, 1, 0, 1, 0, 1, 2, 5, '0);
        tick();
        set_r(1, 1, 1, 1, 0, 1, 2, 6, 16'h1234);
        tick();
        set_r(1, 1, 0, 1, 1, 1, 2, 6, '0);
        tick();

        // R5: one chip enable low blocks a write
        set_r(1, 0, 1, 1, 1, 1, 2, 7, 16'h0F0F);
        tick();
        set_r(0, 1, 1, 1, 1, 1, 2, 7, 16'h0F0F);
        tick();
        set_r(1, 1, 0, 1, 1, 1, 2, 7, '0);
        tick();

        // R6: output enable low hides data
        set_r(1, 1, 0, 0, 1, 1, 2, 7, '0);
        tick();

        // R7: both ports active each cycle on random ownership
        cur_tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            bank_sel = 4'($urandom);
            set_l($urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, 1'($urandom), $urandom_range(0, 5) != 0,
                  1'($urandom), 1'($urandom), $urandom_range(0, 3), $urandom_range(0, DEPTH - 1), 16'($urandom));
            set_r($urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, 1'($urandom), $urandom_range(0, 5) != 0,
                  1'($urandom), 1'($urandom), $urandom_range(0, 3), $urandom_range(0, DEPTH - 1), 16'($urandom));
            tick();
        end

        idle_both();
        tick();
        finish_run();
    end

endmodule